// File: doc/BRIEF.md
# Write-Once Output Code Keeper

This block holds the setting of a 10-bit output code in a small bank of write-once cells and decides which value sits in the live DAC register. A bus command decoder in front of it delivers one-cycle strobes: load the DAC register directly, commit the current word to the next free cell, or recall the most recent committed word. It also delivers a request for a full internal reset. The block answers with the live DAC code, a thermometer nibble that tells software how many cells are used, and the two control lines that frame the programming of a cell. The first line raises the write supply. The second carries the write pulse.

The cells are modelled as registers that are written at most once each. A per-cell written flag marks them, and these flags power up clear. Power-on reset and the bus reset request do not clear the cells. After either reset the use count is rebuilt from the flags, and the DAC register is loaded with the newest cell. If no cell has been used, it gets the midscale code. Each commit starts a programming window that is timed in system-clock cycles. A busy flag covers the window, and while it is high every command except reset is dropped.

Top module: `nvcode_keeper`

## Requirements
- R1: At most SLOTS commits are accepted, each writing the next unused cell; a commit strobe when all cells are used changes no cell, no count, no status, no DAC code and does not raise busy, so a later recall still returns the last accepted word.
- R2: `used_therm` is a thermometer of the number of used cells: 4'b0000, 4'b0001, 4'b0011, 4'b0111, 4'b1111 for 0 to 4 commits.
- R3: On `rst` or `bus_reset_req` the DAC code becomes the newest used cell, or 10'h200 when no cell is used; cells and the use count survive both resets.
- R4: A recall strobe loads the newest used cell into the DAC code, or 10'h000 when no cell is used.
- R5: An accepted commit loads its word into the DAC code on the same clock edge that accepts it.
- R6: A direct DAC write loads its word into the DAC code and leaves the cells and `used_therm` unchanged.
- R7: After an accepted commit, `prog_supply_en` is high alone for SETUP_CYC cycles. Then `prog_pulse` is high for PULSE_CYC cycles while the supply stays on. Then both fall together.
- R8: `busy` is high for SETUP_CYC+PULSE_CYC cycles from the accepting edge; commit, recall and DAC-write strobes sampled while `busy` is high have no effect.
- R9: Coincident strobes resolve as reset over commit over recall over DAC write; a commit refused because all cells are used counts as absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_reset_req | input | 1 | One-cycle full internal reset request from the bus decoder |
| dac_wr_stb | input | 1 | Load `cmd_word` straight into the DAC register |
| commit_stb | input | 1 | Store `cmd_word` into the next free cell |
| recall_stb | input | 1 | Reload the DAC register from the newest used cell |
| cmd_word | input | CODE_W | Data word for DAC write and commit |
| dac_code | output | CODE_W | Live DAC register |
| used_therm | output | SLOTS | Thermometer count of used cells |
| busy | output | 1 | Programming window in progress |
| prog_supply_en | output | 1 | Write-supply enable for the cell being programmed |
| prog_pulse | output | 1 | Write pulse for the cell being programmed |

## Verification
Several properties are checked every cycle. A written cell never changes again. The use count always equals the number of set flags, and the status nibble always stays a thermometer of that count. The write pulse only occurs inside the supply window and after the full setup lead. An accepted commit or an empty recall lands in the DAC register on the next edge, and while busy the register holds unless a reset arrives. Other behaviour is shown only by the bench's scenarios. These cover the restore values after each kind of reset, that the pulse lasts exactly the set number of cycles, the refusal of a fifth commit as seen through a later recall, and how the arbitration resolves each pair of coincident strobes.

// File: rtl/nvk_pkg.sv
package nvk_pkg;

  typedef enum logic [2:0] {
    NVK_NONE,
    NVK_RESET,
    NVK_COMMIT,
    NVK_RECALL,
    NVK_DACWR
  } nvk_cmd_e;

  // thermometer of n ones, lowest bits first
  function automatic logic [31:0] nvk_thermo(input int n);
    return (32'd1 << n) - 32'd1;
  endfunction

endpackage

// File: rtl/nvk_arbiter.sv
module nvk_arbiter (
  input  logic              rst,
  input  logic              bus_reset_req,
  input  logic              busy,
  input  logic              full,
  input  logic              dac_wr_stb,
  input  logic              commit_stb,
  input  logic              recall_stb,
  output nvk_pkg::nvk_cmd_e cmd
);
  import nvk_pkg::*;

  logic commit_ok;
  assign commit_ok = commit_stb && !full;

  always_comb begin
    cmd = NVK_NONE;
    if (rst || bus_reset_req) cmd = NVK_RESET;
    else if (busy)            cmd = NVK_NONE;
    else if (commit_ok)       cmd = NVK_COMMIT;
    else if (recall_stb)      cmd = NVK_RECALL;
    else if (dac_wr_stb)      cmd = NVK_DACWR;
  end

endmodule

// File: rtl/nvk_slot_bank.sv
module nvk_slot_bank #(
  parameter int CODE_W = 10,
  parameter int SLOTS  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_reset_req,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_data,
  output logic [SLOTS-1:0]  used_therm,
  output logic              full,
  output logic              any_used,
  output logic [CODE_W-1:0] newest
);
  import nvk_pkg::*;

  localparam int IDX_W = $clog2(SLOTS);
  localparam int CNT_W = $clog2(SLOTS + 1);

  logic [CODE_W-1:0] slot_mem [SLOTS];
  logic [SLOTS-1:0]  written_q = '0;   // blank cells at configuration
  logic [CNT_W-1:0]  count_q;
  logic [SLOTS-1:0]  therm_q;
  logic [CNT_W-1:0]  fill;
  logic [IDX_W-1:0]  wr_idx;
  logic [IDX_W-1:0]  rd_idx;
  logic              reload;

  assign reload = rst || bus_reset_req;
  assign fill   = CNT_W'($countones(written_q));
  assign wr_idx = IDX_W'(count_q);
  assign rd_idx = IDX_W'(fill - CNT_W'(1));

  // single write port, one cell per commit
  always_ff @(posedge clk) begin
    if (wr_en) slot_mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (wr_en) written_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (reload) begin
      count_q <= fill;
      therm_q <= SLOTS'(nvk_thermo(int'(fill)));
    end else if (wr_en) begin
      count_q <= count_q + CNT_W'(1);
      therm_q <= SLOTS'(nvk_thermo(int'(count_q) + 1));
    end
  end

  assign used_therm = therm_q;
  assign full       = (count_q == CNT_W'(SLOTS));
  assign any_used   = |written_q;
  assign newest     = slot_mem[rd_idx];

  AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (reload)
    count_q == CNT_W'($countones(written_q))) else $error("count drift"); // R3

  AST_STATUS_THERMO: assert property (@(posedge clk) disable iff (reload)
    $countones(therm_q) == int'(count_q) && therm_q == SLOTS'(nvk_thermo(int'(count_q))))
    else $error("status not thermometer"); // R2

  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (reload)
    wr_en |-> !full) else $error("write past last cell"); // R1

  for (genvar g = 0; g < SLOTS; g++) begin : g_once
    AST_NO_REWRITE: assert property (@(posedge clk) disable iff (rst)
      written_q[g] |=> (written_q[g] && $stable(slot_mem[g])))
      else $error("cell rewritten"); // R1
  end

endmodule

// File: rtl/nvk_prog_seq.sv
module nvk_prog_seq #(
  parameter int SETUP_CYC = 2500,
  parameter int PULSE_CYC = 15000
) (
  input  logic clk,
  input  logic rst,
  input  logic abort,
  input  logic start,
  output logic busy,
  output logic supply_en,
  output logic pulse
);
  localparam int MAX_CYC = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_PULSE} seq_e;

  seq_e             state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, supply_q, pulse_q;
  logic [CNT_W:0]   lead_q;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      state_q  <= S_IDLE;
      cnt_q    <= '0;
      busy_q   <= 1'b0;
      supply_q <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start) begin
          state_q  <= S_SETUP;
          cnt_q    <= CNT_W'(SETUP_CYC - 1);
          busy_q   <= 1'b1;
          supply_q <= 1'b1;
        end
        S_SETUP: if (cnt_q == '0) begin
          state_q <= S_PULSE;
          cnt_q   <= CNT_W'(PULSE_CYC - 1);
          pulse_q <= 1'b1;
        end else cnt_q <= cnt_q - CNT_W'(1);
        S_PULSE: if (cnt_q == '0) begin
          state_q  <= S_IDLE;
          busy_q   <= 1'b0;
          supply_q <= 1'b0;
          pulse_q  <= 1'b0;
        end else cnt_q <= cnt_q - CNT_W'(1);
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy      = busy_q;
  assign supply_en = supply_q;
  assign pulse     = pulse_q;

  // supply lead measured for the checks below
  always_ff @(posedge clk) begin
    if (rst || !supply_q) lead_q <= '0;
    else if (!pulse_q)    lead_q <= lead_q + (CNT_W+1)'(1);
  end

  AST_PULSE_IN_SUPPLY: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> supply_q) else $error("pulse without supply"); // R7

  AST_SUPPLY_LEAD: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_q) |-> lead_q >= (CNT_W+1)'(SETUP_CYC)) else $error("short supply lead"); // R7

  AST_BUSY_COVERS: assert property (@(posedge clk) disable iff (rst)
    (supply_q || pulse_q) |-> busy_q) else $error("window outside busy"); // R8

endmodule

// File: rtl/nvcode_keeper.sv
module nvcode_keeper #(
  parameter int CODE_W    = 10,
  parameter int SLOTS     = 4,
  parameter int SETUP_CYC = 2500,
  parameter int PULSE_CYC = 15000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_reset_req,
  input  logic              dac_wr_stb,
  input  logic              commit_stb,
  input  logic              recall_stb,
  input  logic [CODE_W-1:0] cmd_word,
  output logic [CODE_W-1:0] dac_code,
  output logic [SLOTS-1:0]  used_therm,
  output logic              busy,
  output logic              prog_supply_en,
  output logic              prog_pulse
);
  import nvk_pkg::*;

  localparam logic [CODE_W-1:0] MIDSCALE = {1'b1, {(CODE_W-1){1'b0}}};

  nvk_cmd_e          cmd;
  logic              full, any_used, seq_busy;
  logic [CODE_W-1:0] newest;
  logic [CODE_W-1:0] dac_q;

  nvk_arbiter u_arb (
    .rst           (rst),
    .bus_reset_req (bus_reset_req),
    .busy          (seq_busy),
    .full          (full),
    .dac_wr_stb    (dac_wr_stb),
    .commit_stb    (commit_stb),
    .recall_stb    (recall_stb),
    .cmd           (cmd)
  );

  nvk_slot_bank #(.CODE_W(CODE_W), .SLOTS(SLOTS)) u_bank (
    .clk           (clk),
    .rst           (rst),
    .bus_reset_req (bus_reset_req),
    .wr_en         (cmd == NVK_COMMIT),
    .wr_data       (cmd_word),
    .used_therm    (used_therm),
    .full          (full),
    .any_used      (any_used),
    .newest        (newest)
  );

  nvk_prog_seq #(.SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .abort     (bus_reset_req),
    .start     (cmd == NVK_COMMIT),
    .busy      (seq_busy),
    .supply_en (prog_supply_en),
    .pulse     (prog_pulse)
  );

  always_ff @(posedge clk) begin
    case (cmd)
      NVK_RESET:  dac_q <= any_used ? newest : MIDSCALE;
      NVK_COMMIT: dac_q <= cmd_word;
      NVK_RECALL: dac_q <= any_used ? newest : '0;
      NVK_DACWR:  dac_q <= cmd_word;
      default:    dac_q <= dac_q;
    endcase
  end

  assign dac_code = dac_q;
  assign busy     = seq_busy;

  AST_COMMIT_LOADS_DAC: assert property (@(posedge clk) disable iff (rst)
    (cmd == NVK_COMMIT) |=> dac_code == $past(cmd_word)) else $error("commit not loaded"); // R5

  AST_EMPTY_RECALL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cmd == NVK_RECALL && !any_used) |=> dac_code == '0) else $error("empty recall not zero"); // R4

  AST_BUSY_HOLDS_DAC: assert property (@(posedge clk) disable iff (rst)
    (busy && !bus_reset_req) |=> $stable(dac_code)) else $error("dac moved while busy"); // R8

  AST_FULL_COMMIT_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (commit_stb && full && !bus_reset_req) |=> $stable(used_therm)) else $error("full commit counted"); // R1

endmodule

// File: tb/nvcode_keeper_tb.sv
module nvcode_keeper_tb;

  localparam int S = 4;
  localparam int P = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_reset_req = 1'b0;
  logic       dac_wr_stb = 1'b0;
  logic       commit_stb = 1'b0;
  logic       recall_stb = 1'b0;
  logic [9:0] cmd_word = '0;
  logic [9:0] dac_code;
  logic [3:0] used_therm;
  logic       busy, prog_supply_en, prog_pulse;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 1'b0;

  typedef struct {
    logic [9:0] dac;
    logic [3:0] st;
    logic       bsy;
    int         due;
    string      tag;
  } exp_t;

  exp_t exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nvcode_keeper #(.CODE_W(10), .SLOTS(4), .SETUP_CYC(S), .PULSE_CYC(P)) u_dut (
    .clk(clk), .rst(rst), .bus_reset_req(bus_reset_req),
    .dac_wr_stb(dac_wr_stb), .commit_stb(commit_stb), .recall_stb(recall_stb),
    .cmd_word(cmd_word), .dac_code(dac_code), .used_therm(used_therm),
    .busy(busy), .prog_supply_en(prog_supply_en), .prog_pulse(prog_pulse)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // monitor: compares outputs once the expected item is due
  always @(negedge clk) begin
    if (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
      exp_t it;
      it = exp_q.pop_front();
      check(dac_code == it.dac && used_therm == it.st && busy == it.bsy, it.tag,
            {17'd0, busy, used_therm, dac_code}, {17'd0, it.bsy, it.st, it.dac});
    end
  end

  // driver: one-cycle strobes, expectation due one edge later
  task automatic drive(input bit r, input bit g, input bit c, input bit a, input bit d,
                       input logic [9:0] w, input logic [9:0] edac, input logic [3:0] est,
                       input bit ebusy, input string tag);
    exp_t it;
    rst = r; bus_reset_req = g; commit_stb = c; recall_stb = a; dac_wr_stb = d; cmd_word = w;
    it.dac = edac; it.st = est; it.bsy = ebusy; it.due = cyc + 1; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    rst = 1'b0; bus_reset_req = 1'b0; commit_stb = 1'b0; recall_stb = 1'b0; dac_wr_stb = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (S + P + 2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(dac_code == 10'h200 && used_therm == 4'b0000 && !busy && !prog_supply_en && !prog_pulse,
          "R3 power-on blank midscale", {busy, used_therm, dac_code}, {1'b0, 4'b0000, 10'h200});

    drive(0,0,0,1,0, 10'h000, 10'h000, 4'b0000, 0, "R4 recall empty gives zero");
    drive(0,0,0,0,1, 10'h155, 10'h155, 4'b0000, 0, "R6 dac write");
    drive(0,0,1,0,0, 10'h0AB, 10'h0AB, 4'b0001, 1, "R5 R2 first commit");

    // R7: programming window shape, j = 0 right after the accepting edge
    begin
      int bad = 0;
      for (int j = 0; j <= S + P; j++) begin
        bit es, ep, eb;
        es = (j < S + P); ep = (j >= S) && (j < S + P); eb = (j < S + P);
        if (prog_supply_en != es || prog_pulse != ep || busy != eb) bad++;
        @(negedge clk);
      end
      check(bad == 0, "R7 R8 supply lead, pulse width, busy span", bad, 0);
    end

    drive(0,0,1,0,0, 10'h123, 10'h123, 4'b0011, 1, "R2 second commit");
    drive(0,0,0,0,1, 10'h3FF, 10'h123, 4'b0011, 1, "R8 dac write dropped while busy");
    drive(0,0,0,1,0, 10'h000, 10'h123, 4'b0011, 1, "R8 recall dropped while busy");
    wait_idle();

    drive(0,0,0,0,1, 10'h010, 10'h010, 4'b0011, 0, "R6 dac write keeps status");
    drive(0,0,0,1,0, 10'h000, 10'h123, 4'b0011, 0, "R4 recall newest cell");
    drive(0,0,0,0,1, 10'h010, 10'h010, 4'b0011, 0, "R6 dac write before reset");
    drive(0,1,0,0,0, 10'h000, 10'h123, 4'b0011, 0, "R3 bus reset restores newest");

    drive(0,0,1,1,1, 10'h2EE, 10'h2EE, 4'b0111, 1, "R9 commit beats recall and write");
    wait_idle();
    drive(0,0,0,1,1, 10'h055, 10'h2EE, 4'b0111, 0, "R9 recall beats dac write");

    drive(0,0,1,0,0, 10'h3C3, 10'h3C3, 4'b1111, 1, "R2 fourth commit");
    wait_idle();
    drive(0,0,1,0,0, 10'h001, 10'h3C3, 4'b1111, 0, "R1 fifth commit refused");
    drive(0,0,0,0,1, 10'h0F0, 10'h0F0, 4'b1111, 0, "R6 dac write when full");
    drive(0,0,0,1,0, 10'h000, 10'h3C3, 4'b1111, 0, "R1 last cell unchanged");
    drive(0,0,0,0,1, 10'h0F0, 10'h0F0, 4'b1111, 0, "R6 dac write");
    drive(0,0,1,1,0, 10'h002, 10'h3C3, 4'b1111, 0, "R9 refused commit yields to recall");
    drive(0,0,1,0,1, 10'h004, 10'h004, 4'b1111, 0, "R9 refused commit yields to dac write");
    drive(0,1,0,0,1, 10'h111, 10'h3C3, 4'b1111, 0, "R9 R3 bus reset beats dac write");
    drive(0,0,0,0,1, 10'h0F0, 10'h0F0, 4'b1111, 0, "R6 dac write before power-on");
    drive(1,0,0,0,0, 10'h000, 10'h3C3, 4'b1111, 0, "R3 power-on keeps cells");

    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R1 all expectations consumed", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule